// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory for a small distributed shared-memory system with a fixed set of nodes. Each memory block owned by this home has a directory entry and a memory word. The entry holds a coherence state (Uncached, Shared or Exclusive) and a sharer bit vector with one bit per node. Caches at the other nodes send request messages to the home: read miss, write miss and data write-back. The home answers with data replies, invalidates and fetch requests, and it keeps its memory and directory up to date.

Requests arrive on a valid/ready port. Each one is decoded against the addressed entry in the cycle it is accepted. The directory and memory are updated in that same cycle, and the resulting messages are sent one per cycle on a valid/ready output. A miss to a block that another node holds Exclusive is resolved in two parts. The home sends a fetch to the owner and marks the block as pending. The owner's write-back then completes the transaction. Requests to a pending block are held off, and all other blocks continue to be served.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, and again after any later reset, every entry is Uncached with an empty sharer set and all memory words are zero. req_ready_o is 1 and msg_valid_o is 0.
- R2: A read miss (req_type_i=0) to an Uncached or Shared block sends one data reply (msg_type_o=0) to the requester, carrying the memory word. The requester is added to the sharer set and the entry becomes Shared.
- R3: A write miss (req_type_i=1) to an Uncached block sends one data reply with the memory word to the requester. The requester becomes the only sharer and the entry becomes Exclusive.
- R4: A write miss to a Shared block sends an invalidate (msg_type_o=1, data 0) to every sharer other than the requester, in ascending node order, and then sends a data reply to the requester. The requester is left as the only sharer and the entry becomes Exclusive.
- R5: A read miss from another node to an Exclusive block sends only a fetch (msg_type_o=2) to the owner. When the owner's write-back arrives, memory takes its data and the requester gets a reply with that data. The sharer set becomes owner plus requester and the entry becomes Shared.
- R6: A write miss from another node to an Exclusive block sends only a fetch-and-invalidate (msg_type_o=3) to the owner. When the owner's write-back arrives, memory takes its data and the requester gets a reply with that data. The requester becomes the only sharer and the entry stays Exclusive.
- R7: A write-back (req_type_i=2) from the Exclusive owner with no fetch pending sends no message. It stores its data into memory, clears the sharer set and returns the entry to Uncached.
- R8: A write-back from a node that is not the Exclusive owner of that block is ignored. No message is sent, and memory and directory are left unchanged.
- R9: While a fetch is pending for a block, the only request to that block that is accepted is the owner's write-back. req_ready_o stays 0 for any other request to that block, while requests to other blocks are accepted.
- R10: While msg_valid_o is 1 and msg_ready_i is 0, the outgoing message stays valid and its type, destination, address and data do not change. At most one message is transferred per cycle.
- R11: A read or write miss from the node that already holds the block Exclusive gets a data reply with the memory word, and the directory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request message valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_src_i | input | NW | Requesting node |
| req_addr_i | input | AW | Block address |
| req_data_i | input | DW | Write-back data |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_ready_i | input | 1 | Outgoing message taken |
| msg_type_o | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dst_o | output | NW | Destination node |
| msg_addr_o | output | AW | Block address |
| msg_data_o | output | DW | Reply data (0 on other types) |

## Verification
The owner's write-back that resolves a pending fetch does two things in one accepted cycle. It updates memory and the directory, and it forwards its data to the waiting requester. The bench first opens a fetch for one block. It then holds a conflicting request against that block and checks that this request is not accepted while a request to another block goes through. After that it presents the write-back and checks the reply's destination and data. Later misses to the same block show which sharers are invalidated and which value memory returns, so both halves of that single cycle are judged at the ports.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    RQ_RD = 2'd0,
    RQ_WR = 2'd1,
    RQ_WB = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MS_DATA      = 2'd0,
    MS_INV       = 2'd1,
    MS_FETCH     = 2'd2,
    MS_FETCH_INV = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/dir_pick.sv
// Lowest set bit of a vector, as one-hot and as index.
module dir_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign oh_o[i] = vec_i[i] & ~seen[i];
    if (i + 1 < N) begin : g_chain
      assign seen[i+1] = seen[i] | vec_i[i];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dir_store.sv
// Directory entries and backing memory, one read port, one write port each.
module dir_store
  import dir_pkg::*;
#(
  parameter int NB    = 8,
  parameter int NODES = 4,
  parameter int DW    = 16,
  localparam int AW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rd_addr_i,
  output dir_state_e       rd_state_o,
  output logic [NODES-1:0] rd_shr_o,
  output logic [DW-1:0]    rd_data_o,
  input  logic             dir_we_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  dir_state_e       wr_state_i,
  input  logic [NODES-1:0] wr_shr_i,
  input  logic             mem_we_i,
  input  logic [DW-1:0]    mem_wdata_i
);
  dir_state_e       st_q  [NB];
  logic [NODES-1:0] shr_q [NB];
  logic [DW-1:0]    mem_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) begin
        st_q[b]  <= ST_UNC;
        shr_q[b] <= '0;
        mem_q[b] <= '0;
      end
    end else begin
      if (dir_we_i) begin
        st_q[wr_addr_i]  <= wr_state_i;
        shr_q[wr_addr_i] <= wr_shr_i;
      end
      if (mem_we_i) mem_q[wr_addr_i] <= mem_wdata_i;
    end
  end

  assign rd_state_o = st_q[rd_addr_i];
  assign rd_shr_o   = shr_q[rd_addr_i];
  assign rd_data_o  = mem_q[rd_addr_i];

  AST_EXC_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && wr_state_i == ST_EXC |-> $countones(wr_shr_i) == 1); // R3
  AST_UNC_NO_SHARERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && wr_state_i == ST_UNC |-> wr_shr_i == '0); // R7
  AST_SHR_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && wr_state_i == ST_SHR |-> wr_shr_i != '0); // R2
endmodule

// File: rtl/dir_policy.sv
// Decodes one request against the addressed entry.
module dir_policy
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int DW    = 16,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [1:0]       kind_i,
  input  logic [NW-1:0]    src_i,
  input  logic [DW-1:0]    data_i,
  input  dir_state_e       state_i,
  input  logic [NODES-1:0] shr_i,
  input  logic [NODES-1:0] owner_oh_i,
  input  logic [NW-1:0]    owner_idx_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             pend_vld_i,
  input  logic [NW-1:0]    pend_req_i,
  input  logic             pend_wr_i,
  output logic             dir_we_o,
  output dir_state_e       st_o,
  output logic [NODES-1:0] shr_o,
  output logic             mem_we_o,
  output logic [NODES-1:0] inv_o,
  output logic             fin_vld_o,
  output msg_kind_e        fin_kind_o,
  output logic [NW-1:0]    fin_dst_o,
  output logic [DW-1:0]    fin_data_o,
  output logic             set_pend_o,
  output logic             set_wr_o,
  output logic             clr_pend_o
);
  logic [NODES-1:0] src_oh, pend_oh;
  logic             self_excl, foreign_excl;

  assign src_oh       = NODES'(1) << src_i;
  assign pend_oh      = NODES'(1) << pend_req_i;
  assign self_excl    = (state_i == ST_EXC) && (owner_oh_i == src_oh);
  assign foreign_excl = (state_i == ST_EXC) && !self_excl;

  always_comb begin
    dir_we_o   = 1'b0;
    st_o       = state_i;
    shr_o      = shr_i;
    mem_we_o   = 1'b0;
    inv_o      = '0;
    fin_vld_o  = 1'b0;
    fin_kind_o = MS_DATA;
    fin_dst_o  = src_i;
    fin_data_o = mem_rdata_i;
    set_pend_o = 1'b0;
    set_wr_o   = 1'b0;
    clr_pend_o = 1'b0;
    case (kind_i)
      RQ_RD: begin
        fin_vld_o = 1'b1;
        if (foreign_excl) begin
          fin_kind_o = MS_FETCH;
          fin_dst_o  = owner_idx_i;
          fin_data_o = '0;
          set_pend_o = 1'b1;
        end else if (!self_excl) begin
          dir_we_o = 1'b1;
          st_o     = ST_SHR;
          shr_o    = shr_i | src_oh;
        end
      end
      RQ_WR: begin
        fin_vld_o = 1'b1;
        if (foreign_excl) begin
          fin_kind_o = MS_FETCH_INV;
          fin_dst_o  = owner_idx_i;
          fin_data_o = '0;
          set_pend_o = 1'b1;
          set_wr_o   = 1'b1;
        end else if (!self_excl) begin
          inv_o    = shr_i & ~src_oh;
          dir_we_o = 1'b1;
          st_o     = ST_EXC;
          shr_o    = src_oh;
        end
      end
      RQ_WB: begin
        if (self_excl) begin
          mem_we_o = 1'b1;
          dir_we_o = 1'b1;
          if (pend_vld_i) begin
            clr_pend_o = 1'b1;
            fin_vld_o  = 1'b1;
            fin_dst_o  = pend_req_i;
            fin_data_o = data_i;
            st_o       = pend_wr_i ? ST_EXC : ST_SHR;
            shr_o      = pend_wr_i ? pend_oh : (pend_oh | src_oh);
          end else begin
            st_o  = ST_UNC;
            shr_o = '0;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NB    = 8,
  parameter int DW    = 16,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_type_i,
  input  logic [NW-1:0] req_src_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          msg_valid_o,
  input  logic          msg_ready_i,
  output logic [1:0]    msg_type_o,
  output logic [NW-1:0] msg_dst_o,
  output logic [AW-1:0] msg_addr_o,
  output logic [DW-1:0] msg_data_o
);
  typedef enum logic {FS_IDLE, FS_SEND} fsm_e;

  fsm_e             fsm_q;
  logic [NODES-1:0] inv_q;
  msg_kind_e        fin_kind_q;
  logic [NW-1:0]    fin_dst_q, src_q;
  logic [DW-1:0]    fin_data_q;
  logic [AW-1:0]    addr_q;

  logic [NB-1:0]    pend_vld_q, pend_wr_q;
  logic [NW-1:0]    pend_req_q [NB];

  dir_state_e       cur_state;
  logic [NODES-1:0] cur_shr, owner_oh, src_oh;
  logic [NW-1:0]    owner_idx;
  logic [DW-1:0]    cur_data;

  logic             pol_dir_we, pol_mem_we, pol_fin_vld;
  logic             pol_set_pend, pol_set_wr, pol_clr_pend;
  dir_state_e       pol_st;
  logic [NODES-1:0] pol_shr, pol_inv;
  msg_kind_e        pol_fin_kind;
  logic [NW-1:0]    pol_fin_dst;
  logic [DW-1:0]    pol_fin_data;

  logic [NODES-1:0] inv_oh;
  logic [NW-1:0]    inv_idx;
  logic             accept, stall, self_own, msg_fire, inv_any;

  dir_store #(.NB(NB), .NODES(NODES), .DW(DW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   (req_addr_i),
    .rd_state_o  (cur_state),
    .rd_shr_o    (cur_shr),
    .rd_data_o   (cur_data),
    .dir_we_i    (accept && pol_dir_we),
    .wr_addr_i   (req_addr_i),
    .wr_state_i  (pol_st),
    .wr_shr_i    (pol_shr),
    .mem_we_i    (accept && pol_mem_we),
    .mem_wdata_i (req_data_i)
  );

  dir_pick #(.N(NODES)) u_owner (
    .vec_i (cur_shr),
    .oh_o  (owner_oh),
    .idx_o (owner_idx)
  );

  dir_policy #(.NODES(NODES), .DW(DW)) u_policy (
    .kind_i      (req_type_i),
    .src_i       (req_src_i),
    .data_i      (req_data_i),
    .state_i     (cur_state),
    .shr_i       (cur_shr),
    .owner_oh_i  (owner_oh),
    .owner_idx_i (owner_idx),
    .mem_rdata_i (cur_data),
    .pend_vld_i  (pend_vld_q[req_addr_i]),
    .pend_req_i  (pend_req_q[req_addr_i]),
    .pend_wr_i   (pend_wr_q[req_addr_i]),
    .dir_we_o    (pol_dir_we),
    .st_o        (pol_st),
    .shr_o       (pol_shr),
    .mem_we_o    (pol_mem_we),
    .inv_o       (pol_inv),
    .fin_vld_o   (pol_fin_vld),
    .fin_kind_o  (pol_fin_kind),
    .fin_dst_o   (pol_fin_dst),
    .fin_data_o  (pol_fin_data),
    .set_pend_o  (pol_set_pend),
    .set_wr_o    (pol_set_wr),
    .clr_pend_o  (pol_clr_pend)
  );

  dir_pick #(.N(NODES)) u_inv (
    .vec_i (inv_q),
    .oh_o  (inv_oh),
    .idx_o (inv_idx)
  );

  // Only the owner's write-back may enter a block with a fetch outstanding.
  assign src_oh      = NODES'(1) << req_src_i;
  assign self_own    = (cur_state == ST_EXC) && (owner_oh == src_oh);
  assign stall       = pend_vld_q[req_addr_i] && !(req_type_i == RQ_WB && self_own);
  assign req_ready_o = (fsm_q == FS_IDLE) && !stall;
  assign accept      = req_valid_i && req_ready_o;

  assign inv_any     = |inv_q;
  assign msg_valid_o = (fsm_q == FS_SEND);
  assign msg_fire    = msg_valid_o && msg_ready_i;
  assign msg_type_o  = inv_any ? MS_INV : fin_kind_q;
  assign msg_dst_o   = inv_any ? inv_idx : fin_dst_q;
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = inv_any ? '0 : fin_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q      <= FS_IDLE;
      inv_q      <= '0;
      fin_kind_q <= MS_DATA;
      fin_dst_q  <= '0;
      fin_data_q <= '0;
      addr_q     <= '0;
      src_q      <= '0;
    end else if (fsm_q == FS_IDLE) begin
      if (accept) begin
        inv_q      <= pol_inv;
        fin_kind_q <= pol_fin_kind;
        fin_dst_q  <= pol_fin_dst;
        fin_data_q <= pol_fin_data;
        addr_q     <= req_addr_i;
        src_q      <= req_src_i;
        if (pol_fin_vld || (|pol_inv)) fsm_q <= FS_SEND;
      end
    end else if (msg_fire) begin
      if (inv_any) inv_q <= inv_q & ~inv_oh;
      else         fsm_q <= FS_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= '0;
      pend_wr_q  <= '0;
      for (int b = 0; b < NB; b++) pend_req_q[b] <= '0;
    end else if (accept) begin
      if (pol_set_pend) begin
        pend_vld_q[req_addr_i] <= 1'b1;
        pend_wr_q[req_addr_i]  <= pol_set_wr;
        pend_req_q[req_addr_i] <= req_src_i;
      end else if (pol_clr_pend) begin
        pend_vld_q[req_addr_i] <= 1'b0;
      end
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_type_o) && $stable(msg_dst_o)
      && $stable(msg_addr_o) && $stable(msg_data_o)); // R10
  AST_PEND_ONLY_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && pend_vld_q[req_addr_i] |-> req_type_i == RQ_WB); // R9
  AST_INV_NOT_REQUESTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MS_INV |-> msg_dst_o != src_q); // R4
  AST_FETCH_MARKS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_type_o == MS_FETCH || msg_type_o == MS_FETCH_INV)
      |-> pend_vld_q[msg_addr_o]); // R5
  AST_NO_ACCEPT_WHILE_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !req_ready_o); // R10
endmodule

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;
  localparam int NODES = 4;
  localparam int NB    = 8;
  localparam int DW    = 16;

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  typ;
    logic [1:0]  src;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [2:0]  n;
    logic [19:0] m0;
    logic [19:0] m1;
    logic [19:0] m2;
  } vec_t;

  function automatic logic [19:0] mm(int t, int d, int v);
    return {t[1:0], d[1:0], v[15:0]};
  endfunction

  function automatic vec_t mv(int rq, int t, int s, int a, int d, int n,
                              logic [19:0] m0, logic [19:0] m1, logic [19:0] m2);
    vec_t v;
    v.rq = rq[3:0]; v.typ = t[1:0]; v.src = s[1:0]; v.addr = a[2:0];
    v.data = d[15:0]; v.n = n[2:0]; v.m0 = m0; v.m1 = m1; v.m2 = m2;
    return v;
  endfunction

  // req types: 0 RD, 1 WR, 2 WB. msg types: 0 DATA, 1 INV, 2 FETCH, 3 FETCH_INV
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    mv(3,  1, 0, 1, 0,  1, mm(0,0,0),  0, 0),             // R3
    mv(11, 0, 0, 1, 0,  1, mm(0,0,0),  0, 0),             // R11
    mv(7,  2, 0, 1, 10, 0, 0, 0, 0),                      // R7
    mv(2,  0, 1, 1, 0,  1, mm(0,1,10), 0, 0),             // R2
    mv(2,  0, 2, 1, 0,  1, mm(0,2,10), 0, 0),             // R2
    mv(2,  0, 3, 1, 0,  1, mm(0,3,10), 0, 0),             // R2
    mv(4,  1, 2, 1, 0,  3, mm(1,1,0), mm(1,3,0), mm(0,2,10)), // R4
    mv(8,  2, 1, 1, 99, 0, 0, 0, 0),                      // R8
    mv(5,  0, 0, 1, 0,  1, mm(2,2,0),  0, 0),             // R5
    mv(5,  2, 2, 1, 20, 1, mm(0,0,20), 0, 0),             // R5
    mv(4,  1, 3, 1, 0,  3, mm(1,0,0), mm(1,2,0), mm(0,3,20)), // R4
    mv(6,  1, 1, 1, 0,  1, mm(3,3,0),  0, 0),             // R6
    mv(6,  2, 3, 1, 30, 1, mm(0,1,30), 0, 0),             // R6
    mv(7,  2, 1, 1, 40, 0, 0, 0, 0),                      // R7
    mv(7,  1, 0, 1, 0,  1, mm(0,0,40), 0, 0),             // R7
    mv(7,  2, 0, 1, 41, 0, 0, 0, 0),                      // R7
    mv(8,  2, 3, 2, 55, 0, 0, 0, 0),                      // R8
    mv(8,  0, 3, 2, 0,  1, mm(0,3,0),  0, 0),             // R8
    mv(2,  0, 0, 7, 0,  1, mm(0,0,0),  0, 0),             // R2
    mv(4,  1, 0, 7, 0,  1, mm(0,0,0),  0, 0)              // R4
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_type_i = '0;
  logic [1:0]  req_src_i = '0;
  logic [2:0]  req_addr_i = '0;
  logic [15:0] req_data_i = '0;
  logic        msg_valid_o;
  logic        msg_ready_i = 1'b1;
  logic [1:0]  msg_type_o;
  logic [1:0]  msg_dst_o;
  logic [2:0]  msg_addr_o;
  logic [15:0] msg_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [19:0] got [4];
  int          got_n;
  logic        addr_bad;

  always #10 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .NB(NB), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_type_i(req_type_i),
    .req_src_i(req_src_i), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_type_o(msg_type_o),
    .msg_dst_o(msg_dst_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
  );

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic send_req(input int t, input int s, input int a, input int d);
    @(negedge clk);
    req_valid_i = 1'b1; req_type_i = t[1:0]; req_src_i = s[1:0];
    req_addr_i = a[2:0]; req_data_i = d[15:0];
    #1;
    for (int w = 0; w < 50 && !req_ready_o; w++) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic collect(input int a);
    got_n = 0;
    addr_bad = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (msg_valid_o && msg_ready_i) begin
        if (got_n < 4) got[got_n] = {msg_type_o, msg_dst_o, msg_data_o};
        if (msg_addr_o != a[2:0]) addr_bad = 1'b1;
        got_n++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready_o == 1'b1, "R1", req_ready_o, 1);
    chk(msg_valid_o == 1'b0, "R1", msg_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1 && msg_valid_o == 1'b0, "R1", {req_ready_o, msg_valid_o}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      logic [19:0] em [3];
      string tag;
      em[0] = v.m0; em[1] = v.m1; em[2] = v.m2;
      tag = $sformatf("R%0d vec%0d", v.rq, i);
      send_req(v.typ, v.src, v.addr, v.data);
      collect(v.addr);
      chk(got_n == v.n, tag, got_n, v.n);
      chk(!addr_bad, tag, addr_bad, 0);
      for (int k = 0; k < 3; k++)
        if (k < v.n && k < got_n) chk(got[k] == em[k], tag, got[k], em[k]);
    end

    // R9: block 3 made pending, conflicting request held, block 4 still served
    send_req(1, 1, 3, 0); collect(3);
    chk(got_n == 1 && got[0] == mm(0,1,0), "R9 setup", got[0], mm(0,1,0));
    send_req(0, 2, 3, 0); collect(3);
    chk(got_n == 1 && got[0] == mm(2,1,0), "R5 fetch", got[0], mm(2,1,0));
    @(negedge clk);
    req_valid_i = 1'b1; req_type_i = 2'd0; req_src_i = 2'd3; req_addr_i = 3'd3; req_data_i = '0;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk(req_ready_o == 1'b0, "R9 stall", req_ready_o, 0);
      chk(msg_valid_o == 1'b0, "R9 stall", msg_valid_o, 0);
      @(negedge clk);
    end
    req_type_i = 2'd1; #1;
    chk(req_ready_o == 1'b0, "R9 stall wr", req_ready_o, 0);
    req_type_i = 2'd0; req_src_i = 2'd0; req_addr_i = 3'd4; #1;
    chk(req_ready_o == 1'b1, "R9 other block", req_ready_o, 1);
    @(posedge clk); #1; req_valid_i = 1'b0;
    collect(4);
    chk(got_n == 1 && got[0] == mm(0,0,0), "R9 other block", got[0], mm(0,0,0));
    send_req(2, 1, 3, 70); collect(3);
    chk(got_n == 1 && got[0] == mm(0,2,70), "R5 forward", got[0], mm(0,2,70));
    send_req(1, 3, 3, 0); collect(3);
    chk(got_n == 3, "R5 sharers", got_n, 3);
    chk(got[0] == mm(1,1,0) && got[1] == mm(1,2,0) && got[2] == mm(0,3,70),
        "R5 sharers", got[2], mm(0,3,70));

    // R10: backpressure holds the message
    msg_ready_i = 1'b0;
    send_req(1, 2, 5, 0);
    @(negedge clk);
    chk(msg_valid_o == 1'b1, "R10", msg_valid_o, 1);
    begin
      logic [22:0] first;
      first = {msg_type_o, msg_dst_o, msg_addr_o, msg_data_o};
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(msg_valid_o && {msg_type_o, msg_dst_o, msg_addr_o, msg_data_o} == first,
            "R10", {msg_type_o, msg_dst_o, msg_addr_o, msg_data_o}, first);
      end
    end
    msg_ready_i = 1'b1;
    @(negedge clk);
    chk(msg_valid_o == 1'b0, "R10 one", msg_valid_o, 0);

    // R1: later reset clears memory
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk(msg_valid_o == 1'b0 && req_ready_o == 1'b1, "R1 rerst", {req_ready_o, msg_valid_o}, 2'b10);
    rst_ni = 1'b1;
    send_req(0, 1, 3, 0); collect(3);
    chk(got_n == 1 && got[0] == mm(0,1,0), "R1 mem cleared", got[0], mm(0,1,0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule